// File: doc/BRIEF.md
# Out-of-Order Multithreaded Kernel Pipeline

This block is a pipelined datapath for a data-parallel kernel. It runs many independent threads of that kernel and can start a new thread on every clock. Each thread computes an address from its two operands and then makes one read from an external memory whose latency is not known in advance. The address comes from the operands, so the read cannot be issued before the thread starts. When it issues that read, the thread does not hold the pipeline. It is parked instead. The values it still needs go into a small on-chip context store, in a slot that the memory tag names. Threads launched after it keep moving.

When the memory answers, in any order, the response tag selects the parked context. The thread is then restored into the post-read stage, and its result leaves two cycles later, labelled with its thread ID. A thread may also be launched as a direct thread, which skips the read and enters the post-read stage at once. Results therefore leave out of launch order, and a later thread may finish before an earlier one.

The kernel is fixed. The read address is `(a + b) mod 2^AW`. The saved live value is `(a - b) mod 2^DW`. The result is `(live + read_data) mod 2^DW`. A direct thread uses zero for the read data.

Top module: `mt_kernel_pipe`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` and `mem_req_valid` are low, and `in_ready` is high for a read thread (`in_direct`=0), because all context slots are free.
- R2: A read thread accepted at a clock edge (`in_valid`&`in_ready`, `in_direct`=0) produces a request on the next cycle. `mem_req_valid` is 1, `mem_req_addr` = `(in_a + in_b) mod 2^AW`, and `mem_req_tag` is a slot that has no other request outstanding.
- R3: A response accepted at an edge (`mem_rsp_valid`=1) gives `out_valid`=1 two cycles later. `out_tid` is the ID of the thread that owns `mem_rsp_tag`, and `out_res` = `(a - b + mem_rsp_data) mod 2^DW`.
- R4: Responses may arrive in any order. Results leave in the order in which their responses were accepted, not in launch order.
- R5: While fewer than SLOTS read threads are outstanding, a read thread is accepted on every cycle (`in_ready`=1). This holds whatever responses are pending.
- R6: When SLOTS read threads are outstanding, `in_ready` is low for a read thread and no request is issued. A slot freed by a response does not count until the next cycle.
- R7: A direct thread (`in_direct`=1) accepted at an edge gives `out_valid` two cycles later, with its own `out_tid` and `out_res` = `(a - b) mod 2^DW`.
- R8: If `mem_rsp_valid` is high in the same cycle as a direct launch, `in_ready` is low and the response takes the post-read stage. If no response is present, a direct thread is accepted.
- R9: Every accepted thread yields exactly one result.
- R10: A slot released by a response may be handed to a new read thread on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Thread launch request |
| in_ready | output | 1 | Launch accepted this cycle |
| in_direct | input | 1 | 1: thread skips the memory read |
| in_tid | input | TID_W | Thread ID |
| in_a | input | DW | First operand |
| in_b | input | DW | Second operand |
| mem_req_valid | output | 1 | Read request issued |
| mem_req_tag | output | $clog2(SLOTS) | Context slot of the requesting thread |
| mem_req_addr | output | AW | Read address |
| mem_rsp_valid | input | 1 | Read data returning, always accepted |
| mem_rsp_tag | input | $clog2(SLOTS) | Tag of the returning request |
| mem_rsp_data | input | DW | Returned data |
| out_valid | output | 1 | Result valid |
| out_tid | output | TID_W | Thread ID of the result |
| out_res | output | DW | Thread result |

## Verification
The bench builds the block with SLOTS=4, DW=16, AW=10 and TID_W=8. With only four context slots, a burst of launches fills the store within a few cycles, so the refusal path and same-cycle slot reuse are exercised many times in a short run. A memory model with random latency and random choice of the next response produces wide reordering. A reverse-order drain is also run, and direct launches are mixed in so that they often collide with returning data.

// File: rtl/mt_kernel_pipe.sv
module mt_kernel_pipe #(
  parameter int TID_W = 8,
  parameter int DW    = 16,
  parameter int AW    = 12,
  parameter int SLOTS = 8,
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_direct,
  input  logic [TID_W-1:0] in_tid,
  input  logic [DW-1:0]    in_a,
  input  logic [DW-1:0]    in_b,
  output logic             mem_req_valid,
  output logic [SW-1:0]    mem_req_tag,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [SW-1:0]    mem_rsp_tag,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             out_valid,
  output logic [TID_W-1:0] out_tid,
  output logic [DW-1:0]    out_res
);

  logic [SLOTS-1:0] busy, set_v, clr_v;
  logic [SW-1:0]    pick;
  logic             any_free;
  logic [TID_W-1:0] ctx_tid  [SLOTS];
  logic [DW-1:0]    ctx_live [SLOTS];

  logic             p_v;
  logic [TID_W-1:0] p_tid;
  logic [DW-1:0]    p_live, p_data;

  always_comb begin
    any_free = 1'b0;
    pick     = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (!busy[i]) begin
        any_free = 1'b1;
        pick     = SW'(i);
      end
  end

  assign in_ready = in_direct ? !mem_rsp_valid : any_free;

  wire take     = in_valid && in_ready;
  wire take_rd  = take && !in_direct;
  wire take_dir = take && in_direct;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    if (take_rd)       set_v[pick]        = 1'b1;
    if (mem_rsp_valid) clr_v[mem_rsp_tag] = 1'b1;
  end

  always_ff @(posedge clk)
    if (rst) busy <= '0;
    else     busy <= (busy | set_v) & ~clr_v;

  always_ff @(posedge clk)
    if (take_rd) begin
      ctx_tid[pick]  <= in_tid;
      ctx_live[pick] <= in_a - in_b;
    end

  always_ff @(posedge clk) begin
    if (rst) mem_req_valid <= 1'b0;
    else     mem_req_valid <= take_rd;
    mem_req_tag  <= pick;
    mem_req_addr <= in_a[AW-1:0] + in_b[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) p_v <= 1'b0;
    else     p_v <= mem_rsp_valid || take_dir;
    if (mem_rsp_valid) begin
      p_tid  <= ctx_tid[mem_rsp_tag];
      p_live <= ctx_live[mem_rsp_tag];
      p_data <= mem_rsp_data;
    end else begin
      p_tid  <= in_tid;
      p_live <= in_a - in_b;
      p_data <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= p_v;
    out_tid <= p_tid;
    out_res <= p_live + p_data;
  end

endmodule

module mt_kernel_pipe_chk #(
  parameter int SLOTS = 8,
  localparam int CW   = $clog2(SLOTS + 1)
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic in_direct,
  input logic mem_rsp_valid,
  input logic mem_req_valid,
  input logic out_valid
);
  logic [CW-1:0] open_cnt;
  wire acc_rd  = in_valid && in_ready && !in_direct;
  wire acc_dir = in_valid && in_ready && in_direct;

  always_ff @(posedge clk)
    if (rst) open_cnt <= '0;
    else     open_cnt <= open_cnt + CW'(acc_rd) - CW'(mem_rsp_valid);

  a_r2_req_after_launch: assert property (@(posedge clk) disable iff (rst)
    acc_rd |=> mem_req_valid);
  a_r3_rsp_to_result: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid |=> ##1 out_valid);
  a_r7_direct_to_result: assert property (@(posedge clk) disable iff (rst)
    acc_dir |=> ##1 out_valid);
  a_r8_rsp_wins: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid && in_direct) |-> !in_ready);
  a_r6_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (open_cnt == CW'(SLOTS)) |-> !acc_rd);
  a_r5_free_accepts: assert property (@(posedge clk) disable iff (rst)
    (open_cnt < CW'(SLOTS) && !in_direct) |-> in_ready);
endmodule

bind mt_kernel_pipe mt_kernel_pipe_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_direct(in_direct), .mem_rsp_valid(mem_rsp_valid),
  .mem_req_valid(mem_req_valid), .out_valid(out_valid));

// File: tb/tb_mt_kernel_pipe.sv
module tb_mt_kernel_pipe;
  localparam int TID_W = 8, DW = 16, AW = 10, SLOTS = 4, SW = 2;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_direct = 0;
  logic [TID_W-1:0] in_tid = '0;
  logic [DW-1:0] in_a = '0, in_b = '0;
  logic mem_rsp_valid = 0;
  logic [SW-1:0] mem_rsp_tag = '0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic in_ready, mem_req_valid, out_valid;
  logic [SW-1:0] mem_req_tag;
  logic [AW-1:0] mem_req_addr;
  logic [TID_W-1:0] out_tid;
  logic [DW-1:0] out_res;

  mt_kernel_pipe #(.TID_W(TID_W), .DW(DW), .AW(AW), .SLOTS(SLOTS)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_direct(in_direct), .in_tid(in_tid), .in_a(in_a), .in_b(in_b),
    .mem_req_valid(mem_req_valid), .mem_req_tag(mem_req_tag),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_tid(out_tid), .out_res(out_res));

  always #5 clk = ~clk;

  typedef struct { logic [TID_W-1:0] tid; logic [DW-1:0] res; int due; string req; } exp_t;
  typedef struct { logic [TID_W-1:0] tid; logic [DW-1:0] live; logic [AW-1:0] addr; int due; } rq_t;
  exp_t outq[$];
  rq_t  reqq[$];
  logic [TID_W-1:0] tag_tid [SLOTS];
  logic [DW-1:0]    tag_live[SLOTS];
  logic [AW-1:0]    tag_addr[SLOTS];
  bit               tag_out [SLOTS];
  int               tag_rdy [SLOTS];
  int               tag_seq [SLOTS];

  int n_chk = 0, n_err = 0, cyc = 0, open_n = 0, seqc = 0;
  int launched = 0, results = 0;
  logic [TID_W-1:0] next_tid = '0;

  always @(posedge clk) cyc++;

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return DW'(a) * 16'd37 + 16'd5;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic monitor();
    if (out_valid) begin
      results++;
      if (outq.size() == 0) check(0, "R9", "unexpected result tid", out_tid, 0);
      else begin
        exp_t e = outq.pop_front();
        check(out_tid == e.tid, "R4", "result tid order", out_tid, e.tid);
        check(out_res == e.res, e.req, "result value", out_res, e.res);
        check(cyc == e.due, e.req, "result cycle", cyc, e.due);
      end
    end else if (outq.size() > 0 && outq[0].due <= cyc) begin
      exp_t e = outq.pop_front();
      check(0, e.req, "missing result tid", 0, e.tid);
    end
    if (mem_req_valid) begin
      if (reqq.size() == 0) check(0, "R6", "request without accepted thread", mem_req_tag, 0);
      else begin
        rq_t r = reqq.pop_front();
        check(mem_req_addr == r.addr, "R2", "request address", mem_req_addr, r.addr);
        check(cyc == r.due, "R2", "request cycle", cyc, r.due);
        check(!tag_out[mem_req_tag], "R2", "tag already outstanding", mem_req_tag, 0);
        tag_tid[mem_req_tag]  = r.tid;
        tag_live[mem_req_tag] = r.live;
        tag_addr[mem_req_tag] = r.addr;
        tag_out[mem_req_tag]  = 1;
        tag_rdy[mem_req_tag]  = cyc + 1 + int'($urandom % 12);
        tag_seq[mem_req_tag]  = seqc++;
      end
    end else if (reqq.size() > 0 && reqq[0].due <= cyc) begin
      rq_t r = reqq.pop_front();
      check(0, "R2", "missing request for tid", 0, r.tid);
    end
  endtask

  // rmode: 0 no response, 1 random ready tag, 2 newest outstanding (reverse order)
  task automatic step(input bit launch, input bit dir, input int rmode);
    int pickt = -1;
    @(negedge clk);
    monitor();
    if (rmode == 1) begin
      int cand[$];
      for (int t = 0; t < SLOTS; t++) if (tag_out[t] && tag_rdy[t] <= cyc) cand.push_back(t);
      if (cand.size() > 0) pickt = cand[$urandom % cand.size()];
    end else if (rmode == 2) begin
      int best = -1;
      for (int t = 0; t < SLOTS; t++)
        if (tag_out[t] && (pickt < 0 || tag_seq[t] > best)) begin pickt = t; best = tag_seq[t]; end
    end
    if (pickt >= 0) begin
      exp_t e;
      mem_rsp_valid = 1;
      mem_rsp_tag   = SW'(pickt);
      mem_rsp_data  = memf(tag_addr[pickt]);
      e.tid = tag_tid[pickt];
      e.res = tag_live[pickt] + mem_rsp_data;
      e.due = cyc + 2;
      e.req = "R3";
      outq.push_back(e);
      tag_out[pickt] = 0;
    end else mem_rsp_valid = 0;
    if (launch) begin
      bit expr;
      in_valid  = 1;
      in_direct = dir;
      in_tid    = next_tid;
      in_a      = DW'($urandom);
      in_b      = DW'($urandom);
      #1;
      if (dir) begin
        expr = (pickt < 0);
        check(in_ready == expr, "R8", "direct launch ready", in_ready, expr);
      end else begin
        expr = (open_n < SLOTS);
        // R10: a slot freed last cycle is already excluded from open_n
        check(in_ready == expr, expr ? "R5" : "R6", "read launch ready", in_ready, expr);
      end
      if (in_ready) begin
        launched++;
        next_tid++;
        if (dir) begin
          exp_t e;
          e.tid = in_tid; e.res = in_a - in_b; e.due = cyc + 2; e.req = "R7";
          outq.push_back(e);
        end else begin
          rq_t r;
          r.tid = in_tid; r.live = in_a - in_b;
          r.addr = in_a[AW-1:0] + in_b[AW-1:0]; r.due = cyc + 1;
          reqq.push_back(r);
          open_n++;
        end
      end
    end else begin
      in_valid  = 0;
      in_direct = 0;
    end
    if (pickt >= 0) open_n--;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_err++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  initial begin
    for (int t = 0; t < SLOTS; t++) begin tag_out[t] = 0; tag_rdy[t] = 0; tag_seq[t] = 0; end
    repeat (3) begin
      @(negedge clk);
      check(!out_valid && !mem_req_valid, "R1", "outputs idle in reset", {out_valid, mem_req_valid}, 0);
    end
    rst = 0;
    @(negedge clk);
    check(!out_valid && !mem_req_valid, "R1", "outputs idle after reset", {out_valid, mem_req_valid}, 0);
    check(in_ready == 1, "R1", "ready after reset", in_ready, 1);

    // R5/R6: fill all slots back to back, then be refused
    for (int i = 0; i < SLOTS + 3; i++) step(1, 0, 0);
    // R4: drain newest first
    for (int i = 0; i < SLOTS + 4; i++) step(0, 0, 2);
    // R10: refill, free one slot while launching, then reuse it
    for (int i = 0; i < SLOTS; i++) step(1, 0, 0);
    step(1, 0, 2);
    step(1, 0, 0);
    // R8: direct launch colliding with a response, then without one
    step(1, 1, 2);
    step(1, 1, 0);
    for (int i = 0; i < SLOTS + 4; i++) step(0, 0, 2);

    // mixed random traffic
    for (int i = 0; i < 3000; i++)
      step(($urandom % 10) < 7, ($urandom % 4) == 0, 1);
    for (int i = 0; i < 400 && (open_n > 0 || outq.size() > 0 || reqq.size() > 0); i++)
      step(0, 0, 1);
    step(0, 0, 0);
    step(0, 0, 0);

    check(outq.size() == 0 && reqq.size() == 0, "R9", "pending items at end", outq.size(), 0);
    check(results == launched, "R9", "result count", results, launched);
    finish_run();
  end
endmodule